// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two binary floating-point operands, each made of a sign bit, a biased exponent field and a fraction field with an implicit leading one. The default widths give the 32-bit single-precision layout: bit 31 is the sign, bits 30..23 hold the exponent with a bias of 127, and bits 22..0 hold the fraction. The operand with the larger magnitude sets the result exponent. The other significand is shifted right to line up with it, keeping two extra low bits and a sticky bit. The two significands are then added or subtracted according to their signs. The raw result is normalized, rounded to nearest with ties to even, and normalized again when rounding carries out of the significand.

Special encodings are decoded on entry. An all-ones exponent marks infinity when the fraction is zero and NaN when it is not. A zero exponent marks zero, and any fraction beside it is discarded, so denormal inputs count as zero. The result never encodes a denormal: a result too small for the normal range becomes a signed zero and raises the underflow flag. A result too large becomes a signed infinity and raises the overflow flag. The adder accepts one operand pair per cycle when `in_valid` is high. It presents the result, the flags and `out_valid` one clock later and holds them while no new pair arrives.

Top module: `fp_adder`

## Requirements
- R1: Fields decode as value = (-1)^sign x 1.fraction x 2^(exponent-127); 0xC0A00000 reads as -5.0 and -0.75 is written 0xBF400000, so -5.0 + 0 returns 0xC0A00000 and 0.75 + -1.5 returns 0xBF400000.
- R2: For two normal or zero operands the result is the exact sum rounded once to the output format, including when the smaller operand is shifted past every kept bit.
- R3: A rounded result whose exponent reaches 255 or more gives an all-ones exponent with a zero fraction, the sign of the sum, and ovf_flag = 1.
- R4: A nonzero exact result below 2^-126 in magnitude gives a zero word with the sign of the sum (bit 31 only) and unf_flag = 1.
- R5: Rounding is to nearest; an exact halfway case goes to the neighbour whose lowest fraction bit is 0.
- R6: When rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent rises by one (0x3FFFFFFF + 2^-24 gives 0x40000000).
- R7: If either operand is NaN, the result is the quiet NaN 0x7FC00000 with both flags clear.
- R8: +inf plus -inf gives 0x7FC00000. Infinity plus any non-NaN operand of other kind gives that infinity with both flags clear.
- R9: Operands of opposite sign and equal magnitude give +0 (0x00000000). Two zeros give -0 only when both are negative.
- R10: An operand with exponent 0 and a nonzero fraction acts as a zero of its sign, and no output ever has exponent 0 with a nonzero fraction.
- R11: After reset out_valid, the result and the flags are 0. out_valid is in_valid delayed by one clock, and the result and flags do not change in a cycle that follows one with in_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| out_valid | output | 1 | Result present |
| sum | output | EXP_W+FRAC_W+1 | Rounded sum |
| ovf_flag | output | 1 | Result overflowed to infinity |
| unf_flag | output | 1 | Result flushed to zero |

## Verification
A reduced 8-bit format (4-bit exponent, 3-bit fraction) is driven with every operand pair and compared with an exact integer sum rounded in the bench. This catches an alignment that drops the sticky bit, which would turn inexact sums into false ties and round them the wrong way. It also catches a normalizer that leaves the exponent off by one after massive cancellation, and an overflow test made before the rounding carry is applied. Directed single-precision pairs target halfway ties with an even and an odd low bit, a rounding carry that must move the result up to the next power of two, subtraction across a far-shifted operand that borrows through the sticky bit, cancellation to +0, and sums that land just below the normal range. A design that got the zero sign wrong would return -0 on cancellation. A design that passed NaN fractions through, or let infinity set the overflow flag, would show a wrong word or a stray flag.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       mant_o,
  output fpadd_pkg::fp_cls_e    cls_o
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] ffield;

  assign sign_o = word_i[EXP_W+FRAC_W];
  assign efield = word_i[EXP_W+FRAC_W-1:FRAC_W];
  assign ffield = word_i[FRAC_W-1:0];

  always_comb begin
    exp_o  = efield;
    mant_o = {1'b1, ffield};
    cls_o  = fpadd_pkg::CLS_NORM;
    if (efield == '0) begin
      // denormals collapse to a zero of the same sign
      exp_o  = '0;
      mant_o = '0;
      cls_o  = fpadd_pkg::CLS_ZERO;
    end else if (efield == EXP_ONES) begin
      cls_o = (ffield != '0) ? fpadd_pkg::CLS_NAN : fpadd_pkg::CLS_INF;
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic               sign_a_i,
  input  logic [EXP_W-1:0]   exp_a_i,
  input  logic [FRAC_W:0]    mant_a_i,
  input  logic               sign_b_i,
  input  logic [EXP_W-1:0]   exp_b_i,
  input  logic [FRAC_W:0]    mant_b_i,
  output logic               sign_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic [FRAC_W+4:0]  sum_o
);
  localparam int MW  = FRAC_W + 1;   // significand with hidden bit
  localparam int VW  = 2 * MW + 3;   // shifter width: kept bits plus sticky field
  localparam int CAP = MW + 3;       // any larger shift lands wholly in sticky

  logic             swap;
  logic             s_big, s_sml;
  logic [EXP_W-1:0] e_big, e_sml, diff;
  logic [MW-1:0]    m_big, m_sml;
  logic [VW-1:0]    vec, shd;
  logic [MW+2:0]    big_x, sml_x;
  logic             sticky;
  int               amt;

  always_comb begin
    swap   = {exp_b_i, mant_b_i} > {exp_a_i, mant_a_i};
    s_big  = swap ? sign_b_i : sign_a_i;
    s_sml  = swap ? sign_a_i : sign_b_i;
    e_big  = swap ? exp_b_i  : exp_a_i;
    e_sml  = swap ? exp_a_i  : exp_b_i;
    m_big  = swap ? mant_b_i : mant_a_i;
    m_sml  = swap ? mant_a_i : mant_b_i;
    diff   = e_big - e_sml;
    amt    = (int'(diff) > CAP) ? CAP : int'(diff);
    vec    = {m_sml, {(MW+3){1'b0}}};
    shd    = vec >> amt;
    sticky = |shd[MW:0];
    big_x  = {m_big, 3'b000};
    sml_x  = {shd[VW-1 -: MW+2], sticky};
    if (s_big ^ s_sml) sum_o = {1'b0, big_x} - {1'b0, sml_x};
    else               sum_o = {1'b0, big_x} + {1'b0, sml_x};
    sign_o = s_big;
    exp_o  = e_big;
  end
endmodule

// File: rtl/fpadd_norm_round.sv
module fpadd_norm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W+4:0]     sum_i,
  input  logic [EXP_W-1:0]      exp_i,
  input  logic                  sign_i,
  input  logic                  zero_sign_i,
  output logic [EXP_W+FRAC_W:0] word_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  localparam int MW      = FRAC_W + 1;
  localparam int NW      = MW + 3;             // significand, guard, round, sticky
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  logic [NW-1:0] n;
  logic [MW:0]   mr;
  logic          up, found;
  int            e, lz;

  always_comb begin
    n      = '0;
    e      = 0;
    lz     = 0;
    found  = 1'b0;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    if (sum_i[NW]) begin
      n = {sum_i[NW:2], sum_i[1] | sum_i[0]};
      e = int'(exp_i) + 1;
    end else begin
      for (int i = NW - 1; i >= 0; i--) begin
        if (!found) begin
          if (sum_i[i]) found = 1'b1;
          else          lz    = lz + 1;
        end
      end
      n = sum_i[NW-1:0] << lz;
      e = int'(exp_i) - lz;
    end
    up = n[2] & (n[1] | n[0] | n[3]);
    mr = {1'b0, n[NW-1:3]} + {{MW{1'b0}}, up};
    if (mr[MW]) e = e + 1;
    if (sum_i == '0) begin
      word_o = {zero_sign_i, {(EXP_W+FRAC_W){1'b0}}};
    end else if (e < 1) begin
      unf_o  = 1'b1;
      word_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
    end else if (e >= EXP_TOP) begin
      ovf_o  = 1'b1;
      word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      word_o = {sign_i, e[EXP_W-1:0], mr[MW] ? {FRAC_W{1'b0}} : mr[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp_adder.sv
module fp_adder #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [EXP_W+FRAC_W:0]    op_a,
  input  logic [EXP_W+FRAC_W:0]    op_b,
  output logic                     out_valid,
  output logic [EXP_W+FRAC_W:0]    sum,
  output logic                     ovf_flag,
  output logic                     unf_flag
);
  import fpadd_pkg::*;

  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  logic [W-1:0]     ops [2];
  logic             sgn [2];
  logic [EXP_W-1:0] ex  [2];
  logic [FRAC_W:0]  mn  [2];
  fp_cls_e          cls [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .word_i (ops[g]),
      .sign_o (sgn[g]),
      .exp_o  (ex[g]),
      .mant_o (mn[g]),
      .cls_o  (cls[g])
    );
  end

  logic             dp_sign;
  logic [EXP_W-1:0] dp_exp;
  logic [FRAC_W+4:0] dp_sum;
  logic [W-1:0]     dp_word;
  logic             dp_ovf, dp_unf;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sign_a_i (sgn[0]), .exp_a_i (ex[0]), .mant_a_i (mn[0]),
    .sign_b_i (sgn[1]), .exp_b_i (ex[1]), .mant_b_i (mn[1]),
    .sign_o   (dp_sign), .exp_o (dp_exp), .sum_o (dp_sum)
  );

  fpadd_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sum_i       (dp_sum),
    .exp_i       (dp_exp),
    .sign_i      (dp_sign),
    .zero_sign_i (sgn[0] & sgn[1]),
    .word_o      (dp_word),
    .ovf_o       (dp_ovf),
    .unf_o       (dp_unf)
  );

  // next-state selection: special operands override the datapath
  logic [W-1:0] res_d;
  logic         ovf_d, unf_d;
  always_comb begin
    res_d = dp_word;
    ovf_d = dp_ovf;
    unf_d = dp_unf;
    if (cls[0] == CLS_NAN || cls[1] == CLS_NAN ||
        (cls[0] == CLS_INF && cls[1] == CLS_INF && sgn[0] != sgn[1])) begin
      res_d = QNAN;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else if (cls[0] == CLS_INF) begin
      res_d = {sgn[0], INF_MAG};
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else if (cls[1] == CLS_INF) begin
      res_d = {sgn[1], INF_MAG};
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid <= 1'b0;
      sum       <= '0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum      <= res_d;
        ovf_flag <= ovf_d;
        unf_flag <= unf_d;
      end
    end
  end
endmodule

// File: rtl/fp_adder_chk.sv
module fp_adder_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] sum,
  input logic                  ovf_flag,
  input logic                  unf_flag
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [EXP_W-1:0]  o_exp;
  logic [FRAC_W-1:0] o_frac;
  logic              a_nan, b_nan;
  assign o_exp  = sum[W-2:FRAC_W];
  assign o_frac = sum[FRAC_W-1:0];
  assign a_nan  = (op_a[W-2:FRAC_W] == '1) && (op_a[FRAC_W-1:0] != '0);
  assign b_nan  = (op_b[W-2:FRAC_W] == '1) && (op_b[FRAC_W-1:0] != '0);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(ovf_flag) && $stable(unf_flag)));
  assert_ovf_is_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (o_exp == '1 && o_frac == '0 && !unf_flag));
  assert_unf_is_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (o_exp == '0 && o_frac == '0));
  assert_no_denorm_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_exp == '0) |-> (o_frac == '0));
  assert_nan_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_nan || b_nan)) |=> (sum == QNAN && !ovf_flag && !unf_flag));
endmodule

bind fp_adder fp_adder_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ok),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .sum       (sum),
  .ovf_flag  (ovf_flag),
  .unf_flag  (unf_flag)
);

// File: tb/fp_adder_test.sv
module fp_adder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int total = 0;
  int bad   = 0;

  // full-size instance
  logic        in_v = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        ov32;
  logic [31:0] s32;
  logic        of32, uf32;

  fp_adder uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_v), .op_a (a32), .op_b (b32),
    .out_valid (ov32), .sum (s32), .ovf_flag (of32), .unf_flag (uf32)
  );

  // reduced 8-bit instance for the exhaustive sweep
  logic       in_vs = 1'b0;
  logic [7:0] as = '0, bs = '0;
  logic       ovs;
  logic [7:0] ss;
  logic       ofs, ufs;

  fp_adder #(.EXP_W(4), .FRAC_W(3)) uut_small (
    .clk (clk), .rst_n (rst_n), .in_valid (in_vs), .op_a (as), .op_b (bs),
    .out_valid (ovs), .sum (ss), .ovf_flag (ofs), .unf_flag (ufs)
  );

  task automatic chk(input string req, input logic [33:0] got, input logic [33:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got ovf=%b unf=%b word=%h, expected ovf=%b unf=%b word=%h",
               req, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, output logic [33:0] got);
    @(negedge clk);
    a32  = a;
    b32  = b;
    in_v = 1'b1;
    @(posedge clk);
    #1;
    got = {of32, uf32, s32};
  endtask

  task automatic t32(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp_w, input logic eo, input logic eu);
    logic [33:0] got;
    run32(a, b, got);
    chk(req, got, {eo, eu, exp_w});
  endtask

  // exact reference for 1/4/3 format, bias 7, values in units of 2^-9
  function automatic logic [9:0] ref_small(input logic [7:0] a, input logic [7:0] b);
    int ea, fa, eb, fb, va, vb, s, m, p, e, sh, mant, rem, half;
    logic neg;
    ea = int'(a[6:3]); fa = int'(a[2:0]);
    eb = int'(b[6:3]); fb = int'(b[2:0]);
    if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0) ||
        (ea == 15 && eb == 15 && a[7] != b[7])) return {2'b00, 8'h7C};
    if (ea == 15) return {2'b00, a[7], 7'h78};
    if (eb == 15) return {2'b00, b[7], 7'h78};
    va = (ea == 0) ? 0 : ((8 + fa) << (ea - 1));
    vb = (eb == 0) ? 0 : ((8 + fb) << (eb - 1));
    s  = (a[7] ? -va : va) + (b[7] ? -vb : vb);
    if (s == 0) return {2'b00, a[7] & b[7], 7'h00};
    neg = (s < 0);
    m   = neg ? -s : s;
    p   = 0;
    for (int i = 0; i < 31; i++) if (((m >> i) & 1) == 1) p = i;
    e = p - 2;
    if (e < 1) return {2'b01, neg, 7'h00};
    sh   = p - 3;
    mant = m >> sh;
    rem  = m - (mant << sh);
    if (sh > 0) begin
      half = 1 << (sh - 1);
      if (rem > half || (rem == half && (mant & 1) == 1)) mant = mant + 1;
    end
    if (mant == 16) begin
      mant = 8;
      e = e + 1;
    end
    if (e >= 15) return {2'b10, neg, 7'h78};
    return {2'b00, neg, e[3:0], mant[2:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [33:0] got;
    logic [31:0] held;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 reset", {of32, uf32, s32}, 34'd0);
    chk("R11 reset valid", {33'd0, ov32}, 34'd0);

    // R1 encodings
    t32("R1 -5.0 + 0",      32'hC0A00000, 32'h00000000, 32'hC0A00000, 1'b0, 1'b0);
    t32("R1 0.75 + -1.5",   32'h3F400000, 32'hBFC00000, 32'hBF400000, 1'b0, 1'b0);
    t32("R1 -5.0 + 0.75",   32'hC0A00000, 32'h3F400000, 32'hC0880000, 1'b0, 1'b0);
    t32("R2 1 + 1",         32'h3F800000, 32'h3F800000, 32'h40000000, 1'b0, 1'b0);
    t32("R2 far shift",     32'h3F800000, 32'h00800000, 32'h3F800000, 1'b0, 1'b0);
    // R3 overflow
    t32("R3 +max + +max",   32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1'b1, 1'b0);
    t32("R3 -max + -max",   32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1'b1, 1'b0);
    // R4 underflow
    t32("R4 pos flush",     32'h00800001, 32'h80800000, 32'h00000000, 1'b0, 1'b1);
    t32("R4 neg flush",     32'h80800001, 32'h00800000, 32'h80000000, 1'b0, 1'b1);
    // R5 ties to even
    t32("R5 tie even down", 32'h3F800000, 32'h33800000, 32'h3F800000, 1'b0, 1'b0);
    t32("R5 tie odd up",    32'h3F800001, 32'h33800000, 32'h3F800002, 1'b0, 1'b0);
    t32("R5 above half",    32'h3F800000, 32'h33800001, 32'h3F800001, 1'b0, 1'b0);
    t32("R5 sub tie",       32'h3F800000, 32'hB3000000, 32'h3F800000, 1'b0, 1'b0);
    // R6 rounding carry
    t32("R6 carry renorm",  32'h3FFFFFFF, 32'h33800000, 32'h40000000, 1'b0, 1'b0);
    // R7 NaN
    t32("R7 nan + 1",       32'h7F800001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0);
    t32("R7 -nan + inf",    32'hFFC00000, 32'h7F800000, 32'h7FC00000, 1'b0, 1'b0);
    // R8 infinities
    t32("R8 inf - inf",     32'h7F800000, 32'hFF800000, 32'h7FC00000, 1'b0, 1'b0);
    t32("R8 -inf + 1",      32'hFF800000, 32'h3F800000, 32'hFF800000, 1'b0, 1'b0);
    t32("R8 1 + inf",       32'h3F800000, 32'h7F800000, 32'h7F800000, 1'b0, 1'b0);
    // R9 zero sign
    t32("R9 cancel",        32'h3F800000, 32'hBF800000, 32'h00000000, 1'b0, 1'b0);
    t32("R9 -0 + -0",       32'h80000000, 32'h80000000, 32'h80000000, 1'b0, 1'b0);
    t32("R9 -0 + +0",       32'h80000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0);
    // R10 denormal inputs
    t32("R10 denorm + 1",   32'h00000001, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0);
    t32("R10 -denorm + -0", 32'h80400000, 32'h80000000, 32'h80000000, 1'b0, 1'b0);
    t32("R10 -denorm + +0", 32'h80400000, 32'h00000000, 32'h00000000, 1'b0, 1'b0);

    // R11 latency and hold
    run32(32'h40000000, 32'h3F800000, got);
    chk("R11 valid one cycle later", {33'd0, ov32}, 34'd1);
    held = s32;
    chk("R11 result 2+1", {of32, uf32, s32}, {2'b00, 32'h40400000});
    @(negedge clk);
    in_v = 1'b0;
    a32  = 32'h7F800001;
    b32  = 32'h00000000;
    @(posedge clk);
    #1;
    chk("R11 valid drops", {33'd0, ov32}, 34'd0);
    chk("R11 result held", {of32, uf32, s32}, {2'b00, held});

    // R2..R10 exhaustive sweep of the reduced format
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        logic [9:0] e10;
        @(negedge clk);
        as    = i[7:0];
        bs    = j[7:0];
        in_vs = 1'b1;
        e10   = ref_small(i[7:0], j[7:0]);
        @(posedge clk);
        #1;
        chk("R2 sweep", {24'd0, ofs, ufs, ss}, {24'd0, e10});
      end
    end
    @(negedge clk);
    in_vs = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule